// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the hazard controller for a five-stage in-order integer pipeline whose stages run fetch (IF), decode (ID), execute (EX), memory (MEM) and write-back (WB). Each cycle it reads the register specifiers of the instructions in ID and EX, and the destination fields held in the EX/MEM and MEM/WB latches. From these it derives the bypass multiplexer selects for the two EX operands and for store data in MEM. It also derives the hold and bubble controls for each stage and a description of any stall it raises: the stage where the stall occurred and the register that caused it.

A run-time input turns bypassing on or off. When bypassing is on, dependencies resolve in EX. The only stall is a load that is followed at once by a consumer: that consumer waits one cycle in EX. When bypassing is off, a consumer is held in ID until every older writer of its source has left the pipeline. After a halt is fetched, the block tells the fetch stage to stop. Instructions already in flight are unaffected. The block carries no data stream, so all its pins are plain level controls with no valid/ready handshake. Every output except the halt freeze is combinational from the current inputs.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When bypassing is on and a used EX source matches the destination of a non-load writer in EX/MEM, that operand's select is 1 (take from EX/MEM). This holds even if MEM/WB writes the same register.
- R2: When bypassing is on and a used EX source matches only a MEM/WB writer, the select is 2 (take from MEM/WB). Otherwise the select is 0 (take the value read in ID).
- R3: Register 0 never causes a dependency: it produces no bypass select, no stall and no fetch hold.
- R4: When bypassing is on and a used EX source matches a load in EX/MEM, the EX stage stalls. hold_if, hold_id and hold_ex are 1, bubble_mem is 1 and bubble_ex is 0.
- R5: When bypassing is on and a store in MEM has a nonzero data register that matches a MEM/WB writer, st_fwd is 1. Otherwise st_fwd is 0.
- R6: When bypassing is off, all selects and st_fwd are 0 and EX never stalls. A used ID source that matches the destination of a writer in EX, EX/MEM or MEM/WB stalls ID. hold_if and hold_id are 1, bubble_ex is 1, and hold_ex and bubble_mem are 0.
- R7: The stall report is stall_valid, stall_stage and stall_reg. stall_stage is 0 for none, 1 for ID and 2 for EX. stall_reg is the register that caused the stall; the rs operand wins over rt. When there is no stall, all three are 0 and every hold and bubble is 0.
- R8: fetch_stop is 1 in any cycle where if_halt is 1. From the clock edge after that, it stays 1 until reset.
- R9: A source whose use bit is 0, or a latch whose write enable is 0, never creates a dependency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fwd_en | input | 1 | 1 enables bypassing |
| id_rs | input | 5 | First source of the instruction in ID |
| id_rs_use | input | 1 | id_rs is read |
| id_rt | input | 5 | Second source of the instruction in ID |
| id_rt_use | input | 1 | id_rt is read |
| ex_rs | input | 5 | First source of the instruction in EX |
| ex_rs_use | input | 1 | ex_rs is read |
| ex_rt | input | 5 | Second source of the instruction in EX |
| ex_rt_use | input | 1 | ex_rt is read |
| ex_dst | input | 5 | Destination of the instruction in EX |
| ex_wen | input | 1 | Instruction in EX writes a register |
| mem_dst | input | 5 | Destination held in EX/MEM |
| mem_wen | input | 1 | EX/MEM entry writes a register |
| mem_load | input | 1 | EX/MEM entry is a load |
| mem_store | input | 1 | EX/MEM entry is a store |
| mem_st_src | input | 5 | Data register of that store |
| wb_dst | input | 5 | Destination held in MEM/WB |
| wb_wen | input | 1 | MEM/WB entry writes a register |
| if_halt | input | 1 | Instruction in IF is a halt |
| fwd_a_sel | output | 2 | rs operand select: 0 none, 1 EX/MEM, 2 MEM/WB |
| fwd_b_sel | output | 2 | rt operand select, same encoding |
| st_fwd | output | 1 | Store data taken from MEM/WB |
| hold_if | output | 1 | IF keeps its instruction |
| hold_id | output | 1 | ID keeps its instruction |
| hold_ex | output | 1 | EX keeps its instruction |
| bubble_ex | output | 1 | Insert a bubble into EX |
| bubble_mem | output | 1 | Insert a bubble into MEM |
| fetch_stop | output | 1 | Stop fetching new instructions |
| stall_valid | output | 1 | A stall is raised this cycle |
| stall_stage | output | 2 | 0 none, 1 ID, 2 EX |
| stall_reg | output | 5 | Register that caused the stall |

## Verification
The hardest cases to reach are a single register that is written by two latches at once while one of them holds a load, and the case where both sources depend on different late producers so that the rs-over-rt rule decides the report. The random stimulus draws every register field from the four lowest register numbers, which includes register 0. Collisions, double producers and register 0 therefore occur in most vectors, under both bypass settings. Directed vectors then pin down the load-with-newer-writer case, the two-operand report order and the halt freeze.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int REG_W = 5;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_EXM  = 2'd1,
    SEL_MWB  = 2'd2
  } fwd_sel_e;

  typedef enum logic [1:0] {
    STG_NONE = 2'd0,
    STG_ID   = 2'd1,
    STG_EX   = 2'd2
  } stall_stg_e;
endpackage

// File: rtl/hz_src_fwd.sv
module hz_src_fwd
  import hz_pkg::*;
#(
  parameter int RW = REG_W
) (
  input  logic          fwd_en,
  input  logic [RW-1:0] src,
  input  logic          src_use,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic          mem_load,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_wen,
  output fwd_sel_e      sel,
  output logic          late
);
  logic live, hit_mem, hit_wb;

  assign live    = fwd_en && src_use && (src != '0);
  assign hit_mem = live && mem_wen && (mem_dst == src);
  assign hit_wb  = live && wb_wen && (wb_dst == src);

  always_comb begin
    sel  = SEL_NONE;
    late = 1'b0;
    if (hit_mem) begin
      if (mem_load) late = 1'b1;
      else          sel  = SEL_EXM;
    end else if (hit_wb) begin
      sel = SEL_MWB;
    end
  end

  always_comb begin
    if (!fwd_en) a_r6_no_sel_off: assert (sel == SEL_NONE && !late);
    if (src == '0) a_r3_r0_inert: assert (sel == SEL_NONE && !late);
  end
endmodule

// File: rtl/hz_id_dep.sv
module hz_id_dep
  import hz_pkg::*;
#(
  parameter int RW = REG_W
) (
  input  logic          fwd_en,
  input  logic [RW-1:0] src,
  input  logic          src_use,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_wen,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_wen,
  output logic          dep
);
  logic live;
  assign live = !fwd_en && src_use && (src != '0);
  assign dep  = live && ((ex_wen  && ex_dst  == src) ||
                         (mem_wen && mem_dst == src) ||
                         (wb_wen  && wb_dst  == src));

  always_comb begin
    if (!src_use) a_r9_unused_src: assert (!dep);
  end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hz_pkg::*;
#(
  parameter int RW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd_en,
  input  logic [RW-1:0] id_rs,
  input  logic          id_rs_use,
  input  logic [RW-1:0] id_rt,
  input  logic          id_rt_use,
  input  logic [RW-1:0] ex_rs,
  input  logic          ex_rs_use,
  input  logic [RW-1:0] ex_rt,
  input  logic          ex_rt_use,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_wen,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic          mem_load,
  input  logic          mem_store,
  input  logic [RW-1:0] mem_st_src,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_wen,
  input  logic          if_halt,
  output logic [1:0]    fwd_a_sel,
  output logic [1:0]    fwd_b_sel,
  output logic          st_fwd,
  output logic          hold_if,
  output logic          hold_id,
  output logic          hold_ex,
  output logic          bubble_ex,
  output logic          bubble_mem,
  output logic          fetch_stop,
  output logic          stall_valid,
  output logic [1:0]    stall_stage,
  output logic [RW-1:0] stall_reg
);
  localparam int NOPS = 2;

  logic [RW-1:0] ex_src  [NOPS];
  logic          ex_use  [NOPS];
  logic [RW-1:0] id_src  [NOPS];
  logic          id_use  [NOPS];
  fwd_sel_e      sel     [NOPS];
  logic          late    [NOPS];
  logic          dep     [NOPS];
  logic          ex_stall, id_stall, halt_q;

  assign ex_src[0] = ex_rs;  assign ex_use[0] = ex_rs_use;
  assign ex_src[1] = ex_rt;  assign ex_use[1] = ex_rt_use;
  assign id_src[0] = id_rs;  assign id_use[0] = id_rs_use;
  assign id_src[1] = id_rt;  assign id_use[1] = id_rt_use;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    hz_src_fwd #(.RW(RW)) u_fwd (
      .fwd_en(fwd_en), .src(ex_src[g]), .src_use(ex_use[g]),
      .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_load(mem_load),
      .wb_dst(wb_dst), .wb_wen(wb_wen), .sel(sel[g]), .late(late[g])
    );
    hz_id_dep #(.RW(RW)) u_dep (
      .fwd_en(fwd_en), .src(id_src[g]), .src_use(id_use[g]),
      .ex_dst(ex_dst), .ex_wen(ex_wen), .mem_dst(mem_dst),
      .mem_wen(mem_wen), .wb_dst(wb_dst), .wb_wen(wb_wen), .dep(dep[g])
    );
  end

  assign fwd_a_sel = sel[0];
  assign fwd_b_sel = sel[1];
  assign st_fwd    = fwd_en && mem_store && (mem_st_src != '0) &&
                     wb_wen && (wb_dst == mem_st_src);

  assign ex_stall = late[0] || late[1];
  assign id_stall = dep[0] || dep[1];

  always_comb begin
    hold_if     = 1'b0;
    hold_id     = 1'b0;
    hold_ex     = 1'b0;
    bubble_ex   = 1'b0;
    bubble_mem  = 1'b0;
    stall_valid = 1'b0;
    stall_stage = STG_NONE;
    stall_reg   = '0;
    if (ex_stall) begin
      hold_if     = 1'b1;
      hold_id     = 1'b1;
      hold_ex     = 1'b1;
      bubble_mem  = 1'b1;
      stall_valid = 1'b1;
      stall_stage = STG_EX;
      stall_reg   = late[0] ? ex_rs : ex_rt;
    end else if (id_stall) begin
      hold_if     = 1'b1;
      hold_id     = 1'b1;
      bubble_ex   = 1'b1;
      stall_valid = 1'b1;
      stall_stage = STG_ID;
      stall_reg   = dep[0] ? id_rs : id_rt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       halt_q <= 1'b0;
    else if (if_halt) halt_q <= 1'b1;
  end
  assign fetch_stop = halt_q || if_halt;

  a_r4_ex_stall_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_stage == STG_EX) |-> (hold_if && hold_id && hold_ex && bubble_mem && !bubble_ex));
  a_r6_id_stall_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_stage == STG_ID) |-> (!fwd_en && hold_if && hold_id && !hold_ex && bubble_ex));
  a_r7_reg_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    stall_valid |-> (stall_reg != '0));
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stop |=> fetch_stop);
  a_r5_store_off: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_en |-> !st_fwd);
endmodule

// File: tb/pipe_hazard_ctrl_bench.sv
module pipe_hazard_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic fwd_en, id_rs_use, id_rt_use, ex_rs_use, ex_rt_use, ex_wen;
  logic mem_wen, mem_load, mem_store, wb_wen, if_halt;
  logic [4:0] id_rs, id_rt, ex_rs, ex_rt, ex_dst, mem_dst, mem_st_src, wb_dst;
  logic [1:0] fwd_a_sel, fwd_b_sel, stall_stage;
  logic st_fwd, hold_if, hold_id, hold_ex, bubble_ex, bubble_mem, fetch_stop, stall_valid;
  logic [4:0] stall_reg;

  int checks = 0;
  int errors = 0;

  pipe_hazard_ctrl u_pipe_hazard_ctrl (.*);

  // expected values
  logic [1:0] x_a, x_b, x_stg;
  logic x_st, x_hif, x_hid, x_hex, x_bex, x_bmem, x_sv;
  logic [4:0] x_reg;

  function automatic logic [2:0] ref_op(input logic [4:0] s, input logic u);
    // {late, sel[1:0]}
    if (!fwd_en || !u || s == 0) return 3'b000;
    if (mem_wen && mem_dst == s) return mem_load ? 3'b100 : 3'b001;
    if (wb_wen && wb_dst == s) return 3'b010;
    return 3'b000;
  endfunction

  function automatic logic ref_dep(input logic [4:0] s, input logic u);
    if (fwd_en || !u || s == 0) return 1'b0;
    return (ex_wen && ex_dst == s) || (mem_wen && mem_dst == s) || (wb_wen && wb_dst == s);
  endfunction

  task automatic compute();
    logic [2:0] oa, ob;
    logic da, db;
    oa = ref_op(ex_rs, ex_rs_use);
    ob = ref_op(ex_rt, ex_rt_use);
    da = ref_dep(id_rs, id_rs_use);
    db = ref_dep(id_rt, id_rt_use);
    x_a = oa[1:0]; x_b = ob[1:0];
    x_st = fwd_en && mem_store && mem_st_src != 0 && wb_wen && wb_dst == mem_st_src;
    {x_hif, x_hid, x_hex, x_bex, x_bmem, x_sv, x_stg, x_reg} = '0;
    if (oa[2] || ob[2]) begin
      {x_hif, x_hid, x_hex, x_bmem, x_sv} = '1;
      x_stg = 2; x_reg = oa[2] ? ex_rs : ex_rt;
    end else if (da || db) begin
      {x_hif, x_hid, x_bex, x_sv} = '1;
      x_stg = 1; x_reg = da ? id_rs : id_rt;
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    compute();
    chk(req, "fwd_a_sel", fwd_a_sel, x_a);
    chk(req, "fwd_b_sel", fwd_b_sel, x_b);
    chk(req, "st_fwd", st_fwd, x_st);
    chk(req, "holds", {hold_if, hold_id, hold_ex, bubble_ex, bubble_mem},
        {x_hif, x_hid, x_hex, x_bex, x_bmem});
    chk(req, "stall_report", {stall_valid, stall_stage, stall_reg}, {x_sv, x_stg, x_reg});
  endtask

  task automatic clear_in();
    {fwd_en, id_rs_use, id_rt_use, ex_rs_use, ex_rt_use, ex_wen} = '0;
    {mem_wen, mem_load, mem_store, wb_wen, if_halt} = '0;
    {id_rs, id_rt, ex_rs, ex_rt, ex_dst, mem_dst, mem_st_src, wb_dst} = '0;
  endtask

  task automatic apply(input string req);
    @(negedge clk); #1;
    check_all(req);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0007));
    clear_in();
    repeat (2) @(negedge clk);
    #1;
    chk("R7", "reset report", {stall_valid, stall_stage, stall_reg}, 0);
    chk("R8", "reset fetch_stop", fetch_stop, 0);
    rst_n = 1'b1;

    // R1: EX/MEM beats MEM/WB
    clear_in(); fwd_en = 1; ex_rs = 3; ex_rs_use = 1;
    mem_dst = 3; mem_wen = 1; wb_dst = 3; wb_wen = 1;
    apply("R1");
    chk("R1", "newest wins", fwd_a_sel, 1);
    // R2: only MEM/WB
    mem_dst = 2; ex_rt = 3; ex_rt_use = 1;
    apply("R2");
    chk("R2", "wb select", fwd_b_sel, 2);
    // R3: r0
    clear_in(); fwd_en = 1; ex_rs_use = 1; mem_wen = 1; mem_load = 1;
    apply("R3");
    chk("R3", "r0 no stall", stall_valid, 0);
    // R4: load in EX/MEM, newer than WB writer -> still stall
    clear_in(); fwd_en = 1; ex_rt = 5; ex_rt_use = 1; ex_rs = 6; ex_rs_use = 1;
    mem_dst = 5; mem_wen = 1; mem_load = 1; wb_dst = 5; wb_wen = 1;
    apply("R4");
    chk("R4", "ex stall stage", stall_stage, 2);
    chk("R7", "rt reported", stall_reg, 5);
    // R5 store data
    clear_in(); fwd_en = 1; mem_store = 1; mem_st_src = 9; wb_dst = 9; wb_wen = 1;
    apply("R5");
    chk("R5", "store fwd", st_fwd, 1);
    // R6 / R7 off, both operands depend, rs reported
    clear_in(); id_rs = 4; id_rs_use = 1; id_rt = 7; id_rt_use = 1;
    ex_dst = 7; ex_wen = 1; wb_dst = 4; wb_wen = 1;
    apply("R6");
    chk("R7", "rs priority", stall_reg, 4);
    chk("R6", "id stage", stall_stage, 1);
    // R9 unused source / disabled write
    clear_in(); fwd_en = 1; ex_rs = 2; mem_dst = 2; mem_wen = 1; mem_load = 1;
    apply("R9");
    chk("R9", "unused no stall", stall_valid, 0);

    // random sweep
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      fwd_en = $urandom_range(0, 1);
      {id_rs_use, id_rt_use, ex_rs_use, ex_rt_use, ex_wen, mem_wen, mem_load, mem_store, wb_wen}
        = 9'($urandom);
      id_rs = 5'($urandom_range(0, 3)); id_rt = 5'($urandom_range(0, 3));
      ex_rs = 5'($urandom_range(0, 3)); ex_rt = 5'($urandom_range(0, 3));
      ex_dst = 5'($urandom_range(0, 3)); mem_dst = 5'($urandom_range(0, 3));
      mem_st_src = 5'($urandom_range(0, 3)); wb_dst = 5'($urandom_range(0, 3));
      #1;
      check_all(fwd_en ? "R1 R2 R4 R5 R7" : "R6 R7");
    end

    // R8 halt freeze
    clear_in();
    @(negedge clk); #1;
    chk("R8", "no halt", fetch_stop, 0);
    if_halt = 1; #1;
    chk("R8", "halt in IF", fetch_stop, 1);
    @(negedge clk); if_halt = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R8", "halt sticky", fetch_stop, 1);
    rst_n = 0; #1;
    chk("R8", "reset clears", fetch_stop, 0);
    @(negedge clk); rst_n = 1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule